// File: doc/BRIEF.md
# Memory Tag Check Unit

The unit checks every load and store against a 4-bit allocation tag that is kept for each 16-byte granule of memory. The requester's pointer carries a key tag in its upper byte. The unit looks up the lock tag of the granule, or of both granules when the access crosses a granule boundary, in an on-block tag store that the granule index addresses. It compares the two and decides whether the access may go ahead.

The mode input selects one of four policies:

- **Off:** checking is disabled.
- **Synchronous:** a mismatch blocks the access and raises a precise fault in the same cycle.
- **Asynchronous:** a mismatch still lets the access complete, and the first faulting pointer is recorded in a sticky status register.
- **Asymmetric:** loads follow the synchronous rule and stores follow the asynchronous rule.

A separate paint command writes one tag into a run of consecutive granules, one granule per cycle. Software uses it when memory is allocated, and again when memory is freed, so that stale pointers stop matching.

The memory itself, the caches and the delivery of the exception lie outside the unit. The `acc_go_o` output is the permission that a memory port would act on.

Top module: `mem_tag_check`

## Requirements
- R1: The key tag is pointer bits [59:56]. The granule index is pointer bits [9:4], which selects one of 64 tag entries. An access inside one granule passes if and only if the key tag equals that granule's lock tag.
- R2: An access of 2^size bytes (size is 0 to 3) whose last byte falls in the next granule is checked against both lock tags. A mismatch on either one is a mismatch. The next granule index wraps from 63 to 0.
- R3: With mode 0 (off), every accepted access has acc_go_o=1 and sync_fault_o=0, and no status is recorded.
- R4: With mode 1 (synchronous), a mismatch gives sync_fault_o=1 and acc_go_o=0 in the request cycle, and no status is recorded.
- R5: With mode 2 (asynchronous), a mismatch gives acc_go_o=1 and sync_fault_o=0. From the next cycle, async_flag_o=1 and async_addr_o holds the faulting pointer.
- R6: With mode 3 (asymmetric), a mismatching load (req_write_i=0) behaves as in R4, and a mismatching store behaves as in R5.
- R7: Once async_flag_o is set, it stays set. async_addr_o keeps the first faulting pointer even when later faults occur.
- R8: async_clr_i clears the flag in the next cycle. If a fault arrives in the same cycle as the clear, the flag stays set and the address of that new fault is captured.
- R9: A paint command with count N≥1 writes its tag into granules base, base+1, … (modulo 64), one granule per cycle. The first write happens at the accepting edge, and set_busy_o stays high for the N−1 following cycles. A count of 0 changes nothing. After a re-paint, a pointer with the old key mismatches.
- R10: While set_busy_o is high, req_ready_o=0, and a request produces neither acc_go_o nor sync_fault_o.
- R11: After reset, every lock tag is 0, async_flag_o=0, set_busy_o=0 and req_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 off, 1 synchronous, 2 asynchronous, 3 asymmetric |
| req_valid_i | input | 1 | Access request present |
| req_write_i | input | 1 | 1 store, 0 load |
| req_ptr_i | input | 64 | Tagged pointer |
| req_size_i | input | 2 | Access size, log2 of bytes |
| req_ready_o | output | 1 | Unit can take a request |
| acc_go_o | output | 1 | Access may complete this cycle |
| sync_fault_o | output | 1 | Precise tag fault |
| set_valid_i | input | 1 | Paint command |
| set_base_i | input | 6 | First granule index to paint |
| set_count_i | input | 7 | Number of granules to paint |
| set_tag_i | input | 4 | Tag to paint |
| set_busy_o | output | 1 | Paint still in progress |
| async_clr_i | input | 1 | Clear recorded async fault |
| async_flag_o | output | 1 | Sticky async fault flag |
| async_addr_o | output | 64 | First faulting pointer |

## Verification
The assertions assume three things about the inputs. Requests arrive only while req_ready_o is high. A paint command is never issued while set_busy_o is high, or in the same cycle as a request. Each input holds steady for the whole clock period. The bench drives everything on the falling edge. It waits out every paint before it issues the next access, and it raises a request during a paint only deliberately, to probe the R10 blocking behaviour. Within those limits it covers boundary-crossing accesses, index wrap-around and concurrent clear-plus-fault.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_ASYNC = 2'd2,
    MODE_ASYM  = 2'd3
  } chk_mode_e;
endpackage

// File: rtl/mtc_tag_store.sv
module mtc_tag_store #(
  parameter int TAG_W = 4,
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [TAG_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [TAG_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [TAG_W-1:0] rdata_b_o
);
  logic [TAG_W-1:0] tag_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               tag_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))     tag_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = tag_q[raddr_a_i];
  assign rdata_b_o = tag_q[raddr_b_i];
endmodule

// File: rtl/mtc_painter.sv
module mtc_painter #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 6,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [IDX_W-1:0] cmd_base_i,
  input  logic [CNT_W-1:0] cmd_count_i,
  input  logic [TAG_W-1:0] cmd_tag_i,
  output logic             busy_o,
  output logic             we_o,
  output logic [IDX_W-1:0] waddr_o,
  output logic [TAG_W-1:0] wdata_o
);
  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] rem_q;
  logic [TAG_W-1:0] tag_q;
  logic             busy_q;
  logic             accept;

  assign accept = cmd_valid_i && !busy_q && (cmd_count_i != '0);

  // first granule is written at the accepting edge
  always_comb begin
    we_o    = accept || busy_q;
    waddr_o = busy_q ? cur_q : cmd_base_i;
    wdata_o = busy_q ? tag_q : cmd_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      rem_q  <= '0;
      tag_q  <= '0;
    end else if (busy_q) begin
      cur_q  <= cur_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
      busy_q <= (rem_q != CNT_W'(1));
    end else if (accept) begin
      cur_q  <= cmd_base_i + 1'b1;
      rem_q  <= cmd_count_i - 1'b1;
      tag_q  <= cmd_tag_i;
      busy_q <= (cmd_count_i != CNT_W'(1));
    end
  end

  assign busy_o = busy_q;

  p_paint_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && rem_q == CNT_W'(1) |=> !busy_q);
  p_paint_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q != '0);
endmodule

// File: rtl/mtc_async_log.sv
module mtc_async_log #(
  parameter int PTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [PTR_W-1:0] addr_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic [PTR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      addr_o <= '0;
    end else if (fault_i && (!flag_o || clr_i)) begin
      flag_o <= 1'b1;
      addr_o <= addr_i;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o && $stable(addr_o));
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !fault_i |=> !flag_o);
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> flag_o);
endmodule

// File: rtl/mem_tag_check.sv
module mem_tag_check
  import mtc_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int TAG_W   = 4,
  parameter int KEY_LSB = 56,
  parameter int GRAN_LG = 4,
  parameter int DEPTH   = 64,
  parameter int SIZE_W  = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [PTR_W-1:0] req_ptr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  output logic             req_ready_o,
  output logic             acc_go_o,
  output logic             sync_fault_o,
  input  logic             set_valid_i,
  input  logic [IDX_W-1:0] set_base_i,
  input  logic [CNT_W-1:0] set_count_i,
  input  logic [TAG_W-1:0] set_tag_i,
  output logic             set_busy_o,
  input  logic             async_clr_i,
  output logic             async_flag_o,
  output logic [PTR_W-1:0] async_addr_o
);
  chk_mode_e        mode;
  logic             we;
  logic [IDX_W-1:0] waddr;
  logic [TAG_W-1:0] wdata;
  logic [IDX_W-1:0] idx_a, idx_b;
  logic [TAG_W-1:0] lock_a, lock_b, key;
  logic [GRAN_LG:0] end_off;
  logic             spans, mismatch, take, sync_chk, async_fault;

  assign mode = chk_mode_e'(mode_i);

  mtc_painter #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_painter (
    .clk_i, .rst_ni,
    .cmd_valid_i (set_valid_i),
    .cmd_base_i  (set_base_i),
    .cmd_count_i (set_count_i),
    .cmd_tag_i   (set_tag_i),
    .busy_o      (set_busy_o),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata)
  );

  mtc_tag_store #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (idx_a),
    .rdata_a_o (lock_a),
    .raddr_b_i (idx_b),
    .rdata_b_o (lock_b)
  );

  // granule crossing: offset of last byte overflows the granule
  assign end_off = {1'b0, req_ptr_i[GRAN_LG-1:0]}
                 + (((GRAN_LG+1)'(1)) << req_size_i) - (GRAN_LG+1)'(1);
  assign spans   = end_off[GRAN_LG];
  assign idx_a   = req_ptr_i[GRAN_LG +: IDX_W];
  assign idx_b   = idx_a + 1'b1;
  assign key     = req_ptr_i[KEY_LSB +: TAG_W];

  assign mismatch = (key != lock_a) || (spans && (key != lock_b));

  assign req_ready_o = !set_busy_o;
  assign take        = req_valid_i && req_ready_o;

  always_comb begin
    unique case (mode)
      MODE_SYNC: sync_chk = 1'b1;
      MODE_ASYM: sync_chk = !req_write_i;
      default:   sync_chk = 1'b0;
    endcase
  end

  assign sync_fault_o = take && mismatch && sync_chk;
  assign acc_go_o     = take && !(mismatch && sync_chk);
  assign async_fault  = take && mismatch && !sync_chk && (mode != MODE_OFF);

  mtc_async_log #(.PTR_W(PTR_W)) u_log (
    .clk_i, .rst_ni,
    .fault_i (async_fault),
    .addr_i  (req_ptr_i),
    .clr_i   (async_clr_i),
    .flag_o  (async_flag_o),
    .addr_o  (async_addr_o)
  );

  p_sync_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_fault_o |-> !acc_go_o);
  p_off_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && mode == MODE_OFF |-> acc_go_o && !sync_fault_o && !async_fault);
  p_async_go_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && mode == MODE_ASYNC |-> acc_go_o && !sync_fault_o);
  p_asym_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && mode == MODE_ASYM && req_write_i |-> acc_go_o);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_busy_o |-> !acc_go_o && !sync_fault_o);
endmodule

// File: tb/mem_tag_check_tb.sv
module mem_tag_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_ptr = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, acc_go, sync_fault;
  logic        set_valid = 1'b0;
  logic [5:0]  set_base = '0;
  logic [6:0]  set_count = '0;
  logic [3:0]  set_tag = '0;
  logic        set_busy;
  logic        async_clr = 1'b0;
  logic        async_flag;
  logic [63:0] async_addr;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [3:0]  m_tag [64];
  logic        m_flag = 1'b0;
  logic [63:0] m_addr = '0;

  always #4 clk = ~clk;

  mem_tag_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_ptr_i(req_ptr),
    .req_size_i(req_size), .req_ready_o(req_ready), .acc_go_o(acc_go),
    .sync_fault_o(sync_fault), .set_valid_i(set_valid), .set_base_i(set_base),
    .set_count_i(set_count), .set_tag_i(set_tag), .set_busy_o(set_busy),
    .async_clr_i(async_clr), .async_flag_o(async_flag), .async_addr_o(async_addr)
  );

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mkptr(logic [3:0] key, int addr);
    return {4'h0, key, 56'(addr)};
  endfunction

  // one request cycle; checks outputs before the edge, state after it
  task automatic access(string rq, logic v, logic [1:0] md, logic wr,
                        logic [63:0] p, logic [1:0] sz, logic clr);
    logic [55:0] a, b;
    logic mism, sync, e_go, e_sf, e_af;
    @(negedge clk);
    req_valid = v; mode = md; req_write = wr; req_ptr = p; req_size = sz;
    async_clr = clr;
    a = p[55:0];
    b = a + (56'd1 << sz) - 56'd1;
    mism = (p[59:56] != m_tag[a[9:4]]) || (p[59:56] != m_tag[b[9:4]]);
    sync = (md == 2'd1) || (md == 2'd3 && !wr);
    e_go = v && !(mism && sync);
    e_sf = v && mism && sync;
    e_af = v && mism && !sync && md != 2'd0;
    #2;
    chk({rq, " go"}, 64'(acc_go), 64'(e_go));
    chk({rq, " sync_fault"}, 64'(sync_fault), 64'(e_sf));
    if (e_af && (!m_flag || clr)) begin m_flag = 1'b1; m_addr = p; end
    else if (clr) m_flag = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; async_clr = 1'b0;
    #2;
    chk({rq, " flag"}, 64'(async_flag), 64'(m_flag));
    if (m_flag) chk({rq, " addr"}, async_addr, m_addr);
  endtask

  task automatic paint(int base, int cnt, logic [3:0] tg, bit probe);
    @(negedge clk);
    set_valid = 1'b1; set_base = 6'(base); set_count = 7'(cnt); set_tag = tg;
    #2 chk("R9 busy before accept", 64'(set_busy), 64'd0);
    @(negedge clk);
    set_valid = 1'b0;
    for (int k = 0; k < cnt; k++) m_tag[(base + k) % 64] = tg;
    for (int k = 1; k < cnt; k++) begin
      if (probe && k == 1) begin
        req_valid = 1'b1; mode = 2'd1; req_ptr = mkptr(4'hF, base * 16);
        req_size = 2'd0;
      end
      #2;
      chk("R9 busy during paint", 64'(set_busy), 64'd1);
      if (probe && k == 1) begin
        chk("R10 ready low", 64'(req_ready), 64'd0);
        chk("R10 no go", 64'(acc_go), 64'd0);
        chk("R10 no sync fault", 64'(sync_fault), 64'd0);
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    #2 chk("R9 busy after paint", 64'(set_busy), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_tag[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R11 flag", 64'(async_flag), 64'd0);
    chk("R11 busy", 64'(set_busy), 64'd0);
    chk("R11 ready", 64'(req_ready), 64'd1);
    access("R11 zero tags", 1, 2'd1, 0, mkptr(4'h0, 'h3F0), 2'd3, 0);

    paint(4, 4, 4'h5, 1'b1);                                  // granules 4..7
    access("R1 match", 1, 2'd1, 0, mkptr(4'h5, 'h50), 2'd2, 0);
    access("R4 mismatch", 1, 2'd1, 1, mkptr(4'h3, 'h54), 2'd0, 0);
    access("R1 last bytes", 1, 2'd1, 0, mkptr(4'h5, 'h78), 2'd3, 0);
    access("R2 cross", 1, 2'd1, 0, mkptr(4'h5, 'h7C), 2'd3, 0);
    access("R2 cross low", 1, 2'd1, 0, mkptr(4'h0, 'h3E), 2'd2, 0);
    access("R3 off", 1, 2'd0, 1, mkptr(4'h9, 'h60), 2'd1, 0);
    access("R5 async", 1, 2'd2, 1, mkptr(4'h2, 'h44), 2'd0, 0);
    access("R7 second", 1, 2'd2, 0, mkptr(4'h1, 'h64), 2'd0, 0);
    access("R7 idle", 0, 2'd2, 0, '0, 2'd0, 0);
    access("R8 clear", 0, 2'd2, 0, '0, 2'd0, 1);
    access("R5 again", 1, 2'd2, 0, mkptr(4'h7, 'h48), 2'd0, 0);
    access("R8 clear+fault", 1, 2'd2, 1, mkptr(4'hA, 'h4C), 2'd0, 1);
    access("R8 clear2", 0, 2'd3, 0, '0, 2'd0, 1);
    access("R6 load", 1, 2'd3, 0, mkptr(4'h1, 'h40), 2'd0, 0);
    access("R6 store", 1, 2'd3, 1, mkptr(4'h1, 'h40), 2'd0, 0);

    paint(20, 0, 4'h9, 1'b0);
    access("R9 count0", 1, 2'd1, 0, mkptr(4'h0, 20 * 16), 2'd0, 0);
    paint(4, 4, 4'h6, 1'b0);
    access("R9 stale ptr", 1, 2'd1, 0, mkptr(4'h5, 'h50), 2'd0, 0);
    access("R9 new ptr", 1, 2'd1, 0, mkptr(4'h6, 'h70), 2'd0, 0);
    paint(62, 4, 4'hC, 1'b0);
    access("R9 wrap 0", 1, 2'd1, 0, mkptr(4'hC, 'h04), 2'd0, 0);
    access("R9 wrap 63", 1, 2'd1, 0, mkptr(4'hC, 'h3F0), 2'd0, 0);
    access("R2 wrap cross", 1, 2'd1, 0, mkptr(4'hC, 'h3FC), 2'd3, 0);
    access("R9 past wrap", 1, 2'd1, 0, mkptr(4'hC, 'h20), 2'd0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule